// File: doc/BRIEF.md
# Bit-Reversed Strided Address Generator

This block produces the sequence of effective addresses for one vector memory operation. A one-cycle start pulse captures a 64-bit base value, an 11-bit signed stride immediate, a vector-length exponent and a 4-bit mode field. The block then walks an element counter from 0 up to VL-1. For each element it forms an offset, multiplies it by the stride and adds the base. It presents each address through a valid/ready handshake.

In reversing mode the element counter is bit-reversed across log2(VL) bits before it scales the stride. The addresses therefore come out in butterfly order, which suits radix-2 transform data, instead of a plain linear stride. The base is a scalar and is never permuted.

The control is a three-state machine:
- S_IDLE waits for `start_i`. The transition IDLE->RUN takes place on an accepted start.
- S_RUN loads one address into the output register whenever that register is empty or is being accepted. The transition RUN->DRAIN takes place when the address for step VL-1 is loaded.
- S_DRAIN holds the final address until it is accepted. The transition DRAIN->IDLE takes place on that handshake and raises `done_o` for one cycle.

Top module: `revstride_agu`

## Requirements
- R1: Each address equals base + offset * stride, modulo 2^64. The stride is `stride_i` read as an 11-bit two's complement number and sign-extended to 64 bits.
- R2: In reversing mode the offset is the element step with its low L bits mirrored: bit i goes to bit L-1-i. L is the effective vector-length exponent.
- R3: Reversing mode is chosen only when `mode_i[3:2]` is 2'b00 and both `mode_i[1]` (zero-destination) and `mode_i[0]` (zero-source) are 1.
- R4: In every other mode the offset is the element step itself, giving a linear stride.
- R5: With an exponent of 0 (VL = 1), exactly one address is produced and it equals the base.
- R6: `vl_log2_i` values above 6 are treated as 6 (VL = 64).
- R7: After a start pulse at clock edge E0, `valid_o` is low after E0 and high after E1. Exactly VL addresses follow, for steps 0 to VL-1 in that order.
- R8: While `valid_o` is high and `ready_i` is low, the next cycle keeps `valid_o` high and `addr_o` unchanged. No address is lost or repeated.
- R9: `done_o` is high for exactly the one cycle after the final handshake, and `valid_o` is low in that cycle.
- R10: A start pulse that arrives while a vector is in progress is ignored. The addresses of the current vector are unchanged.
- R11: After reset `valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a vector (only accepted when idle) |
| base_i | input | 64 | Scalar base address |
| stride_i | input | 11 | Signed stride immediate (instruction bits 21..31) |
| vl_log2_i | input | 3 | log2 of the vector length, clamped to 6 |
| mode_i | input | 4 | [3:2] mode kind, [1] zero-destination, [0] zero-source |
| ready_i | input | 1 | Consumer accepts `addr_o` this cycle |
| valid_o | output | 1 | `addr_o` holds a valid effective address |
| addr_o | output | 64 | Effective address |
| done_o | output | 1 | One-cycle pulse after the last address is accepted |

## Verification
Directed vectors cover the following cases:
- VL = 1, which must yield only the base.
- VL = 8 and VL = 64 in reversing mode, which tell a mirrored index apart from a linear one.
- Mode fields with three of the four enabling conditions met, which separate the reversing-mode decode from a partial match.
- An exponent of 7, which exposes a missing clamp.
- A negative stride, which exposes a stride extended as unsigned.

Random vectors mix every mode, length and base with random ready throttling. This shows that stalls neither drop nor duplicate an address. A start pulse injected mid-vector with a different base shows that busy-time starts are ignored.

// File: rtl/revstride_pkg.sv
package revstride_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_DRAIN = 2'd2
    } agu_state_e;

    typedef struct packed {
        logic [1:0] kind;
        logic       zero_dst;
        logic       zero_src;
    } agu_mode_t;

    localparam logic [1:0] KIND_NORMAL = 2'b00;

endpackage

// File: rtl/revstride_bitrev.sv
module revstride_bitrev #(
    parameter int MAX_LOG = 6,
    parameter int LOG_W   = $clog2(MAX_LOG + 1)
) (
    input  logic [MAX_LOG-1:0] idx_i,
    input  logic [LOG_W-1:0]   width_i,
    output logic [MAX_LOG-1:0] rev_o
);

    logic [MAX_LOG-1:0] cand [MAX_LOG+1];

    // One mirrored candidate per possible reversal width.
    for (genvar w = 0; w <= MAX_LOG; w++) begin : g_width
        for (genvar i = 0; i < MAX_LOG; i++) begin : g_bit
            if (i < w) begin : g_take
                assign cand[w][i] = idx_i[w-1-i];
            end else begin : g_zero
                assign cand[w][i] = 1'b0;
            end
        end
    end

    always_comb begin
        rev_o = cand[MAX_LOG];
        for (int w = 0; w <= MAX_LOG; w++) begin
            if (width_i == LOG_W'(w)) rev_o = cand[w];
        end
    end

endmodule

// File: rtl/revstride_mac.sv
module revstride_mac #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] ea_o
);

    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] scaled;

    assign idx_ext = ADDR_W'(idx_i);
    assign scaled  = stride_i * idx_ext;   // two's complement product, mod 2^ADDR_W
    assign ea_o    = base_i + scaled;

endmodule

// File: rtl/revstride_agu.sv
module revstride_agu
    import revstride_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int IMM_W   = 11,
    parameter int MAX_LOG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  stride_i,
    input  logic [2:0]        vl_log2_i,
    input  logic [3:0]        mode_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    localparam int IDX_W = MAX_LOG;
    localparam int LOG_W = $clog2(MAX_LOG + 1);

    agu_state_e        state_q, state_d;
    logic [IDX_W-1:0]  step_q;
    logic [LOG_W-1:0]  lg_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_q;
    logic              rev_q;
    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;

    agu_mode_t         mode_in;
    logic              rev_sel;
    logic [LOG_W-1:0]  lg_in;
    logic [IDX_W:0]    vl_full;
    logic [IDX_W-1:0]  vl_last;
    logic [IDX_W-1:0]  rev_idx;
    logic [IDX_W-1:0]  off_idx;
    logic [ADDR_W-1:0] ea;
    logic              take_start;
    logic              load_en;
    logic              handshake;
    logic              at_last;

    // ---------------- mode decode and capture-side conditioning ----------------
    assign mode_in = agu_mode_t'(mode_i);
    assign rev_sel = (mode_in.kind == KIND_NORMAL) && mode_in.zero_dst && mode_in.zero_src;
    assign lg_in   = (32'(vl_log2_i) > MAX_LOG) ? LOG_W'(MAX_LOG) : LOG_W'(vl_log2_i);

    assign vl_full = (IDX_W+1)'(1) << lg_q;
    assign vl_last = IDX_W'(vl_full - 1'b1);

    // ---------------- datapath ----------------
    revstride_bitrev #(.MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_bitrev (
        .idx_i   (step_q),
        .width_i (lg_q),
        .rev_o   (rev_idx)
    );

    assign off_idx = rev_q ? rev_idx : step_q;

    revstride_mac #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mac (
        .base_i   (base_q),
        .stride_i (stride_q),
        .idx_i    (off_idx),
        .ea_o     (ea)
    );

    // ---------------- handshake terms ----------------
    assign take_start = (state_q == S_IDLE) && start_i;
    assign load_en    = (state_q == S_RUN) && (!valid_q || ready_i);
    assign handshake  = valid_q && ready_i;
    assign at_last    = (step_q == vl_last);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i)            state_d = S_RUN;
            S_RUN:   if (load_en && at_last) state_d = S_DRAIN;
            S_DRAIN: if (handshake)          state_d = S_IDLE;
            default:                         state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs and per-vector state ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= '0;
            lg_q     <= '0;
            base_q   <= '0;
            stride_q <= '0;
            rev_q    <= 1'b0;
            valid_q  <= 1'b0;
            addr_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == S_DRAIN) && handshake;
            if (take_start) begin
                step_q   <= '0;
                lg_q     <= lg_in;
                base_q   <= base_i;
                stride_q <= {{(ADDR_W-IMM_W){stride_i[IMM_W-1]}}, stride_i};
                rev_q    <= rev_sel;
            end
            if (load_en) begin
                valid_q <= 1'b1;
                addr_q  <= ea;
                if (!at_last) step_q <= step_q + 1'b1;
            end else if (handshake) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = addr_q;
    assign done_o  = done_q;

    // ---------------- assertions ----------------
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(addr_o)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !valid_o); // R7

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (step_q <= vl_last)); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) && start_i |=> $stable(base_q) && $stable(stride_q)); // R10

    AST_VL1_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) && (lg_q == '0) |-> (off_idx == '0)); // R5

    AST_WIDTH_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lg_q) <= MAX_LOG); // R6

endmodule

// File: tb/revstride_agu_tb_top.sv
module revstride_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [63:0] base_i;
    logic [10:0] stride_i;
    logic [2:0]  vl_log2_i;
    logic [3:0]  mode_i;
    logic        ready_i;
    logic        valid_o;
    logic [63:0] addr_o;
    logic        done_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    revstride_agu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .base_i    (base_i),
        .stride_i  (stride_i),
        .vl_log2_i (vl_log2_i),
        .mode_i    (mode_i),
        .ready_i   (ready_i),
        .valid_o   (valid_o),
        .addr_o    (addr_o),
        .done_o    (done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int eff_log(input logic [2:0] lg);
        return (lg > 3'd6) ? 6 : int'(lg);
    endfunction

    function automatic logic [63:0] mirror(input int k, input int w);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[w-1-i] = k[i];
        return r;
    endfunction

    function automatic logic [63:0] ref_ea(input logic [63:0] b, input logic [10:0] s,
                                           input logic [2:0] lg, input logic [3:0] m, input int k);
        logic [63:0] sx  = {{53{s[10]}}, s};
        bit          rev = (m[3:2] == 2'b00) && m[1] && m[0];
        logic [63:0] idx = rev ? mirror(k, eff_log(lg)) : 64'(k);
        return b + sx * idx;
    endfunction

    task automatic run_vec(input logic [63:0] b, input logic [10:0] s, input logic [2:0] lg,
                           input logic [3:0] m, input int ready_pct, input string tag);
        int          vl      = 1 << eff_log(lg);
        int          count   = 0;
        int          guard   = 0;
        bit          first   = 1'b1;
        bit          stalled = 1'b0;
        bit          poked   = 1'b0;
        logic [63:0] held    = '0;
        @(negedge clk);
        base_i = b; stride_i = s; vl_log2_i = lg; mode_i = m; start_i = 1'b1;
        ready_i = ($urandom % 100) < ready_pct;
        @(negedge clk);
        start_i = 1'b0;
        chk(!valid_o, "R7 no valid one cycle after start", 64'(valid_o), 64'd0);
        ready_i = ($urandom % 100) < ready_pct;
        while (count < vl && guard < 5000) begin
            @(negedge clk);
            guard++;
            start_i = 1'b0;
            base_i  = b;
            if (first) chk(valid_o, "R7 valid two cycles after start", 64'(valid_o), 64'd1);
            first = 1'b0;
            if (stalled) chk(valid_o && addr_o == held, "R8 stalled address held", addr_o, held);
            if (valid_o) chk(addr_o == ref_ea(b, s, lg, m, count), tag, addr_o, ref_ea(b, s, lg, m, count));
            if (count == 1 && !poked) begin
                start_i = 1'b1; base_i = ~b; poked = 1'b1;   // R10 busy start
            end
            ready_i = ($urandom % 100) < ready_pct;
            if (valid_o && ready_i) count++;
            stalled = valid_o && !ready_i;
            held    = addr_o;
        end
        chk(count == vl, "R7 address count", 64'(count), 64'(vl));
        @(negedge clk);
        start_i = 1'b0; base_i = b; ready_i = 1'b0;
        chk(done_o && !valid_o, "R9 done after last handshake", {62'd0, done_o, valid_o}, 64'd2);
        @(negedge clk);
        chk(!done_o && !valid_o, "R9 done lasts one cycle", {62'd0, done_o, valid_o}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005_eed1));
        rst_n = 1'b0; start_i = 1'b0; base_i = '0; stride_i = '0;
        vl_log2_i = '0; mode_i = '0; ready_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(!valid_o && !done_o, "R11 reset state", {62'd0, valid_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !done_o, "R11 idle after reset", {62'd0, valid_o, done_o}, 64'd0);

        run_vec(64'h1000, 11'd8, 3'd0, 4'b0011, 100, "R5 single element equals base");
        run_vec(64'h2000, 11'd8, 3'd3, 4'b0011, 100, "R2 reversed VL8");
        run_vec(64'hFFFF_FFFF_FFFF_FF00, 11'd16, 3'd6, 4'b0011, 60, "R2 reversed VL64 with wrap R1");
        run_vec(64'h3000, 11'd4, 3'd3, 4'b0111, 100, "R3 kind not normal gives linear");
        run_vec(64'h3000, 11'd4, 3'd3, 4'b0010, 100, "R3 only zero-dst gives linear R4");
        run_vec(64'h3000, 11'd4, 3'd3, 4'b0001, 70, "R3 only zero-src gives linear R4");
        run_vec(64'h4000, 11'd2, 3'd7, 4'b0011, 80, "R6 exponent 7 clamped to 6");
        run_vec(64'h8000, 11'h7F8, 3'd4, 4'b0011, 50, "R1 negative stride");
        run_vec(64'h8000, 11'h400, 3'd2, 4'b1100, 100, "R4 linear most negative stride");

        for (int v = 0; v < 40; v++) begin
            logic [63:0] b  = {$urandom, $urandom};
            logic [10:0] s  = 11'($urandom);
            logic [2:0]  lg = 3'($urandom);
            logic [3:0]  m  = ($urandom % 2 == 0) ? 4'b0011 : 4'($urandom);
            int          rp = 30 + int'($urandom % 71);
            run_vec(b, s, lg, m, rp, "R1 R2 R4 random vector");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule